// File: doc/BRIEF.md
# DRAM Command Sequence Timing Scheduler

This block places DRAM commands on a clock-cycle timeline. A memory request reaches it already expanded into an ordered run of commands: precharge, activate, read, read with auto-precharge, write and refresh. The commands arrive one at a time over a valid/ready handshake. For each command the scheduler works out an earliest start cycle and a duration. It then delays the start until the per-bank timing rules allow it and until a free command-bus cycle is found.

The scheduler keeps three kinds of state. A free-running cycle counter starts at reset. Each bank has registers for its most recent command. A small table holds the command-bus cycles already taken. Every accepted command yields one scheduled record: command code, bank, start cycle and end cycle. The end of a command becomes the earliest start of the next command in the same sequence. On the last command of a sequence, a done pulse carries the cycle at which that command completes.

Top module: `dseq_sched`

## Requirements
- R1: The first command of a sequence (`in_first`=1) takes `in_req_start` as its earliest start. Every other command takes the end cycle of the previously scheduled command.
- R2: Command codes on `in_cmd` are 0 precharge, 1 activate, 2 read, 3 read with auto-precharge, 4 write and 5 refresh. With default parameters the durations are: precharge 3 cycles, activate 4, write 6, refresh 21. Both read kinds take 5 + `in_beats` cycles. The end cycle is start + duration.
- R3: A write never starts before the end cycle of the last command recorded for its bank. If its earliest start is sooner, the start moves to that end cycle.
- R4: An activate starts no earlier than 10 cycles (default) after the start of the previous activate on the same bank. Activates on other banks impose no constraint.
- R5: A refresh is recorded as the last command of every bank. Any other command is recorded only for its own bank.
- R6: No two scheduled commands share a start cycle among the recent bus slots kept. A command whose cycle is taken moves to the next free cycle, one cycle at a time.
- R7: No command starts before the cycle count at which it was accepted. The count is zero at reset and rises by one each clock.
- R8: `done` pulses together with the record of a command that had `in_last`=1, and `done_cycle` equals that command's end cycle. `done` stays low for all other records.
- R9: After reset `in_ready` is 1 and `out_valid` and `done` are 0.
- R10: Each accepted command yields exactly one single-cycle `out_valid` record. `in_ready` is low while a command is being placed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Command offered |
| in_ready | output | 1 | Scheduler can accept a command |
| in_cmd | input | 3 | Command code (R2) |
| in_bank | input | BANK_W | Target bank |
| in_first | input | 1 | First command of a sequence |
| in_last | input | 1 | Last command of a sequence |
| in_req_start | input | 32 | Request start cycle, used when `in_first`=1 |
| in_beats | input | BEAT_W | Burst beats for reads |
| out_valid | output | 1 | Scheduled record valid |
| out_cmd | output | 3 | Scheduled command code |
| out_bank | output | BANK_W | Scheduled bank |
| out_start | output | 32 | Start cycle |
| out_end | output | 32 | End cycle |
| done | output | 1 | Sequence finished |
| done_cycle | output | 32 | End cycle of the last command |

## Verification
The bench targets the cases where rules interact:
- A write following a refresh on a different bank. A design that recorded refresh only for its own bank would start that write too early.
- Two writes held to the same refresh end. A missing bus-slot check would give both the same start; a wrong bump would not land on the next cycle.
- Three precharges aimed at one cycle. A scheduler that bumped only once would collide.
- An activate retried too soon on its bank, next to an activate on another bank. A design applying the gap globally would delay the unrelated one.
- A request start in the past. Without clamping to the cycle counter, the command would be scheduled behind the current time.

// File: rtl/dseq_pkg.sv
package dseq_pkg;
   localparam int TIME_W = 32;
   typedef logic [TIME_W-1:0] cyc_t;

   typedef enum logic [2:0] {
      CMD_PRE = 3'd0,
      CMD_ACT = 3'd1,
      CMD_RD  = 3'd2,
      CMD_RDA = 3'd3,
      CMD_WR  = 3'd4,
      CMD_REF = 3'd5
   } cmd_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_PROBE = 1'b1
   } st_e;

   function automatic cyc_t cyc_max(input cyc_t a, input cyc_t b);
      return (a > b) ? a : b;
   endfunction
endpackage

// File: rtl/dseq_bank_hist.sv
module dseq_bank_hist
   import dseq_pkg::*;
#(
   parameter int NBANK  = 4,
   localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              upd,
   input  logic [2:0]        upd_cmd,
   input  logic [BANK_W-1:0] upd_bank,
   input  cyc_t              upd_start,
   input  cyc_t              upd_end,
   input  logic [BANK_W-1:0] q_bank,
   output logic              q_any_vld,
   output cyc_t              q_any_end,
   output logic              q_act_vld,
   output cyc_t              q_act_start
);
   logic [NBANK-1:0] any_vld;
   logic [NBANK-1:0] act_vld;
   cyc_t             any_end   [NBANK];
   cyc_t             act_start [NBANK];

   logic is_ref, is_act;
   assign is_ref = (upd_cmd == CMD_REF);
   assign is_act = (upd_cmd == CMD_ACT);

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic hit_b;
      assign hit_b = (upd_bank == BANK_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            any_vld[b]   <= 1'b0;
            any_end[b]   <= '0;
            act_vld[b]   <= 1'b0;
            act_start[b] <= '0;
         end else if (upd) begin
            if (hit_b || is_ref) begin
               any_vld[b] <= 1'b1;
               any_end[b] <= upd_end;
            end
            if (hit_b && is_act) begin
               act_vld[b]   <= 1'b1;
               act_start[b] <= upd_start;
            end
         end
      end
   end

   assign q_any_vld   = any_vld[q_bank];
   assign q_any_end   = any_end[q_bank];
   assign q_act_vld   = act_vld[q_bank];
   assign q_act_start = act_start[q_bank];
endmodule

// File: rtl/dseq_bus_slots.sv
module dseq_bus_slots
   import dseq_pkg::*;
#(
   parameter int DEPTH = 8,
   localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic clk,
   input  logic rst_n,
   input  cyc_t probe,
   output logic hit,
   input  logic ins,
   input  cyc_t ins_cyc
);
   cyc_t             slot [DEPTH];
   logic [DEPTH-1:0] slot_vld;
   logic [DEPTH-1:0] match;
   logic [PTR_W-1:0] wr_ptr;

   for (genvar i = 0; i < DEPTH; i++) begin : g_slot
      assign match[i] = slot_vld[i] && (slot[i] == probe);

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_vld[i] <= 1'b0;
            slot[i]     <= '0;
         end else if (ins && (wr_ptr == PTR_W'(i))) begin
            slot_vld[i] <= 1'b1;
            slot[i]     <= ins_cyc;
         end
      end
   end

   assign hit = |match;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         wr_ptr <= '0;
      else if (ins)
         wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
   end
endmodule

// File: rtl/dseq_sched.sv
module dseq_sched
   import dseq_pkg::*;
#(
   parameter int NBANK   = 4,
   parameter int BEAT_W  = 4,
   parameter int SLOTS   = 8,
   parameter int T_PRE   = 3,
   parameter int T_ACT   = 4,
   parameter int T_RL    = 5,
   parameter int T_WR    = 6,
   parameter int T_RFC   = 21,
   parameter int ACT_GAP = 10,
   localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic [2:0]        in_cmd,
   input  logic [BANK_W-1:0] in_bank,
   input  logic              in_first,
   input  logic              in_last,
   input  logic [31:0]       in_req_start,
   input  logic [BEAT_W-1:0] in_beats,
   output logic              out_valid,
   output logic [2:0]        out_cmd,
   output logic [BANK_W-1:0] out_bank,
   output logic [31:0]       out_start,
   output logic [31:0]       out_end,
   output logic              done,
   output logic [31:0]       done_cycle
);
   if (NBANK < 2 || (1 << BANK_W) != NBANK) begin : g_bad_nbank
      $error("NBANK must be a power of two of at least 2");
   end
   if (SLOTS < 2) begin : g_bad_slots
      $error("SLOTS must be at least 2");
   end
   if (T_PRE < 1 || T_ACT < 1 || T_RL < 1 || T_WR < 1 || T_RFC < 1) begin : g_bad_dur
      $error("every command duration must be at least one cycle");
   end

   st_e              state;
   cyc_t             now_cnt;
   cyc_t             chain_end;
   cyc_t             cand;
   cyc_t             cur_dur;
   logic [2:0]       cur_cmd;
   logic [BANK_W-1:0] cur_bank;
   logic             cur_last;

   logic accept, place;
   logic slot_hit;
   logic q_any_vld, q_act_vld;
   cyc_t q_any_end, q_act_start;
   cyc_t base, early, rule_start, dur_new, cur_end;

   assign in_ready = (state == ST_IDLE);
   assign accept   = in_valid && in_ready;
   assign place    = (state == ST_PROBE) && !slot_hit;
   assign cur_end  = cand + cur_dur;

   always_comb begin
      unique case (in_cmd)
         CMD_PRE: dur_new = cyc_t'(T_PRE);
         CMD_ACT: dur_new = cyc_t'(T_ACT);
         CMD_RD,
         CMD_RDA: dur_new = cyc_t'(T_RL) + cyc_t'(in_beats);
         CMD_WR:  dur_new = cyc_t'(T_WR);
         CMD_REF: dur_new = cyc_t'(T_RFC);
         default: dur_new = cyc_t'(1);
      endcase
   end

   always_comb begin
      base       = in_first ? in_req_start : chain_end;
      early      = cyc_max(base, now_cnt);
      rule_start = early;
      if (in_cmd == CMD_WR && q_any_vld)
         rule_start = cyc_max(early, q_any_end);
      else if (in_cmd == CMD_ACT && q_act_vld)
         rule_start = cyc_max(early, q_act_start + cyc_t'(ACT_GAP));
   end

   dseq_bank_hist #(.NBANK(NBANK)) u_hist (
      .clk         (clk),
      .rst_n       (rst_n),
      .upd         (place),
      .upd_cmd     (cur_cmd),
      .upd_bank    (cur_bank),
      .upd_start   (cand),
      .upd_end     (cur_end),
      .q_bank      (in_bank),
      .q_any_vld   (q_any_vld),
      .q_any_end   (q_any_end),
      .q_act_vld   (q_act_vld),
      .q_act_start (q_act_start)
   );

   dseq_bus_slots #(.DEPTH(SLOTS)) u_slots (
      .clk     (clk),
      .rst_n   (rst_n),
      .probe   (cand),
      .hit     (slot_hit),
      .ins     (place),
      .ins_cyc (cand)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         now_cnt <= '0;
      else
         now_cnt <= now_cnt + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         chain_end  <= '0;
         cand       <= '0;
         cur_dur    <= '0;
         cur_cmd    <= '0;
         cur_bank   <= '0;
         cur_last   <= 1'b0;
         out_valid  <= 1'b0;
         out_cmd    <= '0;
         out_bank   <= '0;
         out_start  <= '0;
         out_end    <= '0;
         done       <= 1'b0;
         done_cycle <= '0;
      end else begin
         out_valid <= 1'b0;
         done      <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (accept) begin
                  cand     <= rule_start;
                  cur_dur  <= dur_new;
                  cur_cmd  <= in_cmd;
                  cur_bank <= in_bank;
                  cur_last <= in_last;
                  state    <= ST_PROBE;
               end
            end
            ST_PROBE: begin
               if (slot_hit) begin
                  cand <= cand + 1'b1;
               end else begin
                  out_valid <= 1'b1;
                  out_cmd   <= cur_cmd;
                  out_bank  <= cur_bank;
                  out_start <= cand;
                  out_end   <= cur_end;
                  chain_end <= cur_end;
                  if (cur_last) begin
                     done       <= 1'b1;
                     done_cycle <= cur_end;
                  end
                  state <= ST_IDLE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/dseq_sched_chk.sv
module dseq_sched_chk
   import dseq_pkg::*;
#(
   parameter int NBANK  = 4,
   localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_ready,
   input logic              out_valid,
   input logic [2:0]        out_cmd,
   input logic [BANK_W-1:0] out_bank,
   input logic [31:0]       out_start,
   input logic [31:0]       out_end,
   input logic              done,
   input logic [31:0]       done_cycle
);
   logic             prev_vld;
   logic [31:0]      prev_start;
   logic [NBANK-1:0] seen;
   logic [31:0]      last_end [NBANK];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_vld   <= 1'b0;
         prev_start <= '0;
      end else if (out_valid) begin
         prev_vld   <= 1'b1;
         prev_start <= out_start;
      end
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_bk
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            seen[b]     <= 1'b0;
            last_end[b] <= '0;
         end else if (out_valid &&
                      (out_bank == BANK_W'(b) || out_cmd == CMD_REF)) begin
            seen[b]     <= 1'b1;
            last_end[b] <= out_end;
         end
      end
   end

   // R2: every command occupies at least one cycle
   a_r2_end_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_end > out_start);

   // R3: write waits for the end of the bank's last recorded command
   a_r3_write_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_cmd == CMD_WR && seen[out_bank]) |-> out_start >= last_end[out_bank]);

   // R6: consecutive records never share a bus cycle
   a_r6_unique_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && prev_vld) |-> out_start != prev_start);

   // R8: done only with a record, carrying its end cycle
   a_r8_done_with_record: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (out_valid && done_cycle == out_end));

   // R10: records are single-cycle pulses
   a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |=> !out_valid);

   // R10: a record is emitted only when the scheduler is back to accepting
   a_r10_ready_with_record: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> in_ready);
endmodule

bind dseq_sched dseq_sched_chk #(.NBANK(NBANK)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .in_ready   (in_ready),
   .out_valid  (out_valid),
   .out_cmd    (out_cmd),
   .out_bank   (out_bank),
   .out_start  (out_start),
   .out_end    (out_end),
   .done       (done),
   .done_cycle (done_cycle)
);

// File: tb/dseq_sched_tb.sv
module dseq_sched_tb;
   localparam int CLK_PERIOD = 10;
   localparam int NBANK = 4;
   localparam int BANK_W = 2;
   localparam int BEAT_W = 4;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              in_valid = 1'b0;
   logic              in_ready;
   logic [2:0]        in_cmd = '0;
   logic [BANK_W-1:0] in_bank = '0;
   logic              in_first = 1'b0;
   logic              in_last = 1'b0;
   logic [31:0]       in_req_start = '0;
   logic [BEAT_W-1:0] in_beats = '0;
   logic              out_valid;
   logic [2:0]        out_cmd;
   logic [BANK_W-1:0] out_bank;
   logic [31:0]       out_start;
   logic [31:0]       out_end;
   logic              done;
   logic [31:0]       done_cycle;

   int checks = 0;
   int errors = 0;
   int tb_cyc = 0;
   logic [31:0] g_start, g_end, g_dcyc;
   logic        g_done;
   int          g_issue_cyc;

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) if (rst_n) tb_cyc <= tb_cyc + 1;

   dseq_sched #(.NBANK(NBANK), .BEAT_W(BEAT_W)) u_dut (.*);

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic issue(input logic [2:0] c, input int b, input logic f, input logic l,
                        input int rs, input int beats);
      int n;
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      g_issue_cyc  = tb_cyc;
      in_cmd       = c;
      in_bank      = BANK_W'(b);
      in_first     = f;
      in_last      = l;
      in_req_start = rs;
      in_beats     = BEAT_W'(beats);
      in_valid     = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      n = 0;
      while (!out_valid && n < 50) begin
         @(negedge clk);
         n++;
      end
      check("R10 record emitted", {31'd0, out_valid}, 32'd1);
      g_start = out_start;
      g_end   = out_end;
      g_done  = done;
      g_dcyc  = done_cycle;
   endtask

   task automatic t_reset;
      check("R9 ready after reset", {31'd0, in_ready}, 32'd1);
      check("R9 out_valid low", {31'd0, out_valid}, 32'd0);
      check("R9 done low", {31'd0, done}, 32'd0);
   endtask

   task automatic t_chain;
      issue(3'd1, 0, 1'b1, 1'b0, 1000, 0);
      check("R1 first start", g_start, 1000);
      check("R2 activate end", g_end, 1004);
      check("R8 no done on non-last", {31'd0, g_done}, 32'd0);
      issue(3'd2, 0, 1'b0, 1'b1, 0, 4);
      check("R1 chained start", g_start, 1004);
      check("R2 read end", g_end, 1013);
      check("R8 done raised", {31'd0, g_done}, 32'd1);
      check("R8 done cycle", g_dcyc, 1013);
   endtask

   task automatic t_write_hold;
      issue(3'd3, 1, 1'b1, 1'b1, 2000, 8);
      check("R2 read-ap end", g_end, 2013);
      issue(3'd4, 1, 1'b1, 1'b1, 2005, 0);
      check("R3 write held", g_start, 2013);
      check("R2 write end", g_end, 2019);
   endtask

   task automatic t_act_gap;
      issue(3'd1, 2, 1'b1, 1'b1, 3000, 0);
      issue(3'd1, 2, 1'b1, 1'b1, 3002, 0);
      check("R4 same-bank gap", g_start, 3010);
      issue(3'd1, 3, 1'b1, 1'b1, 3003, 0);
      check("R4 other bank free", g_start, 3003);
   endtask

   task automatic t_refresh;
      issue(3'd5, 0, 1'b1, 1'b1, 4000, 0);
      check("R2 refresh end", g_end, 4021);
      issue(3'd4, 3, 1'b1, 1'b1, 4001, 0);
      check("R5 refresh blocks bank3 write", g_start, 4021);
      issue(3'd4, 2, 1'b1, 1'b1, 4002, 0);
      check("R6 bump after shared slot", g_start, 4022);
   endtask

   task automatic t_bus;
      issue(3'd0, 1, 1'b1, 1'b1, 5000, 0);
      check("R6 free slot", g_start, 5000);
      issue(3'd0, 2, 1'b1, 1'b1, 5000, 0);
      check("R6 one bump", g_start, 5001);
      issue(3'd0, 3, 1'b1, 1'b1, 5000, 0);
      check("R6 two bumps", g_start, 5002);
      check("R2 precharge end", g_end, 5005);
   endtask

   task automatic t_clamp;
      issue(3'd0, 0, 1'b1, 1'b1, 0, 0);
      check("R7 clamp to now", g_start, g_issue_cyc);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_chain();
      t_write_hold();
      t_act_gap();
      t_refresh();
      t_bus();
      t_clamp();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      errors++;
      checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule